// File: doc/BRIEF.md
# Pixel Clock Divider Coefficient Search Engine

This engine turns a requested pixel clock, given as an integer number of hertz, into the three divider settings of a frequency synthesizer. The synthesizer produces Fout = (M+2)·Fref / ((N+2)·2^R) from a fixed reference Fref of 14 318 180 Hz. A single start pulse latches the target and a flag that selects the multiplexed two-by-eight pixel mode. The engine then runs a sequential search and finishes with either a one-cycle done pulse with fresh settings or a one-cycle error pulse.

The search first fixes the post-divider exponent R. It then walks N from its top value down to one and skips any N whose reference-per-N rate falls outside the allowed window. For each remaining N it derives a rounded M with a shared iterative divider. A candidate is kept only if the synthesized frequency lies within half a percent of the target, and a later candidate replaces an earlier one. When the scan ends, one more division produces the achieved frequency. All window tests use integer cross-multiplication, so no fractional arithmetic is involved.

Top module: `pll_coef_search`

## Requirements
- R1: After reset, m_o, n_o, r_o and freq_o are zero, and done_o and err_o are low.
- R2: Without the mux flag, R is the largest value in 0..3 for which target·2^R is strictly above 60 000 000 and at most 270 000 000. If no R qualifies, err_o pulses on the cycle after the start is taken.
- R3: With the mux flag set at start, R is 2 whatever the target.
- R4: N is scanned from 31 down to 1. An N is used only when Fref > 600 000·(N+2) and Fref ≤ 8 000 000·(N+2), which for this Fref leaves N in 1..21.
- R5: For each used N, with D = (N+2)·2^R, q = floor((target·D + Fref/2) / Fref) and M = q−2. The candidate is dropped unless 1 ≤ M ≤ 127.
- R6: A candidate is accepted when 200·(M+2)·Fref ≥ 199·target·D and 200·(M+2)·Fref < 201·target·D. The last accepted candidate, which has the lowest N, is reported.
- R7: On success, freq_o = floor((M+2)·Fref / D) for the reported M, N and R.
- R8: If no candidate is accepted, err_o pulses for one cycle, done_o stays low, and m_o, n_o, r_o and freq_o keep their previous values.
- R9: done_o is a one-cycle pulse and is never high together with err_o.
- R10: A start pulse that arrives while a search is running is ignored. The running search completes with the result for its own target.
- R11: m_o, n_o, r_o and freq_o change only in the cycle in which done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; sampled only while idle |
| tgt_hz_i | input | 32 | Requested frequency in Hz |
| mux2x8_i | input | 1 | Multiplexed two-by-eight mode flag; forces R to 2 |
| m_o | output | 7 | Feedback divider setting M |
| n_o | output | 5 | Reference divider setting N |
| r_o | output | 2 | Post-divider exponent R |
| freq_o | output | 32 | Achieved frequency in Hz, truncated |
| done_o | output | 1 | One-cycle pulse: new result valid |
| err_o | output | 1 | One-cycle pulse: no valid setting exists |

## Verification
Some properties can be checked on every cycle from the outputs and the latched target alone, and the assertions cover them. These are:
- the half-percent window of each reported result;
- the M range;
- the reference-per-N window;
- the forced R in multiplexed mode;
- the exclusivity of done and error;
- the holding of the result outputs between completions.

Other behaviour depends on the history of the whole scan, and only the bench scenarios can show it. That covers whether the lowest N actually won, whether R is the highest qualifying exponent, whether error cases leave the previous result untouched, and whether a start during a search is dropped. The bench sweeps targets across and beyond the full band in both modes and compares the outputs against an arithmetic model.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NCHK,
    ST_MDIV,
    ST_MCHK,
    ST_NEXT,
    ST_FDIV
  } srch_st_e;
endpackage

// File: rtl/pll_div_iter.sv
// Restoring unsigned divider, one quotient bit per cycle.
module pll_div_iter #(
  parameter int unsigned W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         done_o,
  output logic [W-1:0] quo_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [W:0]    sh, diff;
  logic          ge;

  always_comb begin
    sh   = {rem_q, quo_q[W-1]};
    ge   = sh >= {1'b0, dvs_q};
    diff = sh - {1'b0, dvs_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q  <= '0;
        quo_q  <= dvd_i;
        dvs_q  <= dvs_i;
        cnt_q  <= CW'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= ge ? diff[W-1:0] : sh[W-1:0];
        quo_q <= {quo_q[W-2:0], ge};
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/pll_r_select.sv
// Picks the highest post-divider exponent whose scaled target lies in the VCO band.
module pll_r_select #(
  parameter int unsigned FREQ_W  = 32,
  parameter int unsigned R_W     = 2,
  parameter int unsigned BAND_LO = 60_000_000,
  parameter int unsigned BAND_HI = 270_000_000,
  parameter int unsigned MUX_R   = 2
) (
  input  logic [FREQ_W-1:0] tgt_i,
  input  logic              mux_i,
  output logic [R_W-1:0]    r_o,
  output logic              ok_o
);
  localparam int unsigned R_MAX = (1 << R_W) - 1;
  localparam int unsigned SW    = FREQ_W + R_MAX + 1;

  logic [R_MAX:0] hit;

  for (genvar i = 0; i <= R_MAX; i++) begin : g_band
    logic [SW-1:0] sc;
    assign sc     = SW'(tgt_i) << i;
    assign hit[i] = (sc > SW'(BAND_LO)) && (sc <= SW'(BAND_HI));
  end

  always_comb begin
    r_o  = '0;
    ok_o = 1'b0;
    for (int i = 0; i <= R_MAX; i++) begin
      if (hit[i]) begin
        r_o  = R_W'(i);
        ok_o = 1'b1;
      end
    end
    if (mux_i) begin
      r_o  = R_W'(MUX_R);
      ok_o = 1'b1;
    end
  end
endmodule

// File: rtl/pll_n_window.sv
// Reference-per-N window: REF_LO < FREF/(N+2) <= REF_HI, by cross-multiplication.
module pll_n_window #(
  parameter int unsigned N_W    = 5,
  parameter int unsigned FREF   = 14_318_180,
  parameter int unsigned REF_LO = 600_000,
  parameter int unsigned REF_HI = 8_000_000
) (
  input  logic [N_W-1:0] n_i,
  output logic           ok_o
);
  localparam int unsigned PW = 64;

  logic [PW-1:0] n_ext;

  always_comb begin
    n_ext = PW'(n_i) + PW'(2);
    ok_o  = (PW'(FREF) > PW'(REF_LO) * n_ext) && (PW'(FREF) <= PW'(REF_HI) * n_ext);
  end
endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
  import pll_search_pkg::*;
#(
  parameter int unsigned FREQ_W  = 32,
  parameter int unsigned FREF    = 14_318_180,
  parameter int unsigned M_W     = 7,
  parameter int unsigned N_W     = 5,
  parameter int unsigned R_W     = 2,
  parameter int unsigned DIV_W   = 48,
  parameter int unsigned WIN_W   = 64,
  parameter int unsigned BAND_LO = 60_000_000,
  parameter int unsigned BAND_HI = 270_000_000,
  parameter int unsigned REF_LO  = 600_000,
  parameter int unsigned REF_HI  = 8_000_000,
  parameter int unsigned MUX_R   = 2,
  parameter int unsigned TOL_DEN = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] tgt_hz_i,
  input  logic              mux2x8_i,
  output logic [M_W-1:0]    m_o,
  output logic [N_W-1:0]    n_o,
  output logic [R_W-1:0]    r_o,
  output logic [FREQ_W-1:0] freq_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int unsigned M_MAX = (1 << M_W) - 1;
  localparam int unsigned N_MAX = (1 << N_W) - 1;
  localparam int unsigned Q_MIN = 3;          // M >= 1
  localparam int unsigned Q_MAX = M_MAX + 2;  // M <= M_MAX

  srch_st_e          st_q;
  logic [FREQ_W-1:0] tgt_q;
  logic              mux_q;
  logic [R_W-1:0]    r_q;
  logic [N_W-1:0]    n_q, best_n_q;
  logic [M_W-1:0]    best_m_q;
  logic              found_q;
  logic [DIV_W-1:0]  q_q;

  logic [R_W-1:0]    r_sel;
  logic              r_ok, n_ok;
  logic              div_go, div_done;
  logic [DIV_W-1:0]  div_dvd, div_dvs, div_quo;

  logic [DIV_W-1:0]  scale_n, scale_b, m_num, f_num;
  logic [WIN_W-1:0]  w_lhs, w_lo, w_hi;
  logic              q_in, accept;
  logic [M_W-1:0]    m_cand;

  pll_r_select #(
    .FREQ_W (FREQ_W),
    .R_W    (R_W),
    .BAND_LO(BAND_LO),
    .BAND_HI(BAND_HI),
    .MUX_R  (MUX_R)
  ) u_rsel (
    .tgt_i(tgt_hz_i),
    .mux_i(mux2x8_i),
    .r_o  (r_sel),
    .ok_o (r_ok)
  );

  pll_n_window #(
    .N_W   (N_W),
    .FREF  (FREF),
    .REF_LO(REF_LO),
    .REF_HI(REF_HI)
  ) u_nwin (
    .n_i (n_q),
    .ok_o(n_ok)
  );

  pll_div_iter #(
    .W(DIV_W)
  ) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_go),
    .dvd_i  (div_dvd),
    .dvs_i  (div_dvs),
    .done_o (div_done),
    .quo_o  (div_quo)
  );

  always_comb begin
    scale_n = (DIV_W'(n_q) + DIV_W'(2)) << r_q;
    scale_b = (DIV_W'(best_n_q) + DIV_W'(2)) << r_q;
    m_num   = DIV_W'(tgt_q) * scale_n + DIV_W'(FREF / 2);
    f_num   = (DIV_W'(best_m_q) + DIV_W'(2)) * DIV_W'(FREF);
    q_in    = (q_q >= DIV_W'(Q_MIN)) && (q_q <= DIV_W'(Q_MAX));
    // +-0.5% window without fractions
    w_lhs   = WIN_W'(TOL_DEN) * WIN_W'(q_q) * WIN_W'(FREF);
    w_lo    = WIN_W'(TOL_DEN - 1) * WIN_W'(tgt_q) * WIN_W'(scale_n);
    w_hi    = WIN_W'(TOL_DEN + 1) * WIN_W'(tgt_q) * WIN_W'(scale_n);
    accept  = q_in && (w_lhs >= w_lo) && (w_lhs < w_hi);
    m_cand  = M_W'(q_q - DIV_W'(2));
  end

  always_comb begin
    div_go  = 1'b0;
    div_dvd = '0;
    div_dvs = '0;
    if (st_q == ST_NCHK && n_ok) begin
      div_go  = 1'b1;
      div_dvd = m_num;
      div_dvs = DIV_W'(FREF);
    end else if (st_q == ST_NEXT && n_q == N_W'(1) && found_q) begin
      div_go  = 1'b1;
      div_dvd = f_num;
      div_dvs = scale_b;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      tgt_q    <= '0;
      mux_q    <= 1'b0;
      r_q      <= '0;
      n_q      <= '0;
      best_n_q <= '0;
      best_m_q <= '0;
      found_q  <= 1'b0;
      q_q      <= '0;
      m_o      <= '0;
      n_o      <= '0;
      r_o      <= '0;
      freq_o   <= '0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            tgt_q   <= tgt_hz_i;
            mux_q   <= mux2x8_i;
            r_q     <= r_sel;
            n_q     <= N_W'(N_MAX);
            found_q <= 1'b0;
            if (r_ok) st_q <= ST_NCHK;
            else      err_o <= 1'b1;
          end
        end
        ST_NCHK: st_q <= n_ok ? ST_MDIV : ST_NEXT;
        ST_MDIV: begin
          if (div_done) begin
            q_q  <= div_quo;
            st_q <= ST_MCHK;
          end
        end
        ST_MCHK: begin
          if (accept) begin
            best_m_q <= m_cand;
            best_n_q <= n_q;
            found_q  <= 1'b1;
          end
          st_q <= ST_NEXT;
        end
        ST_NEXT: begin
          if (n_q == N_W'(1)) begin
            if (found_q) st_q <= ST_FDIV;
            else begin
              err_o <= 1'b1;
              st_q  <= ST_IDLE;
            end
          end else begin
            n_q  <= n_q - N_W'(1);
            st_q <= ST_NCHK;
          end
        end
        ST_FDIV: begin
          if (div_done) begin
            m_o    <= best_m_q;
            n_o    <= best_n_q;
            r_o    <= r_q;
            freq_o <= FREQ_W'(div_quo);
            done_o <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_coef_search_chk.sv
module pll_coef_search_chk #(
  parameter int unsigned FREQ_W  = 32,
  parameter int unsigned FREF    = 14_318_180,
  parameter int unsigned M_W     = 7,
  parameter int unsigned N_W     = 5,
  parameter int unsigned R_W     = 2,
  parameter int unsigned REF_LO  = 600_000,
  parameter int unsigned REF_HI  = 8_000_000,
  parameter int unsigned MUX_R   = 2,
  parameter int unsigned TOL_DEN = 200
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [M_W-1:0]    m_o,
  input logic [N_W-1:0]    n_o,
  input logic [R_W-1:0]    r_o,
  input logic [FREQ_W-1:0] freq_o,
  input logic              done_o,
  input logic              err_o,
  input logic [FREQ_W-1:0] tgt_q,
  input logic              mux_q
);
  localparam int unsigned M_MAX = (1 << M_W) - 1;

  logic [63:0] c_d, c_lhs, c_lo, c_hi, c_n2;

  always_comb begin
    c_n2  = 64'(n_o) + 64'd2;
    c_d   = c_n2 << r_o;
    c_lhs = 64'(TOL_DEN) * (64'(m_o) + 64'd2) * 64'(FREF);
    c_lo  = 64'(TOL_DEN - 1) * 64'(tgt_q) * c_d;
    c_hi  = 64'(TOL_DEN + 1) * 64'(tgt_q) * c_d;
  end

  p_done_err_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_m_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (m_o >= M_W'(1)) && (32'(m_o) <= M_MAX));

  p_n_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (n_o >= N_W'(1)) && (64'(FREF) > 64'(REF_LO) * c_n2)
                && (64'(FREF) <= 64'(REF_HI) * c_n2));

  p_tol_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (c_lhs >= c_lo) && (c_lhs < c_hi));

  p_mux_forces_r_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mux_q) |-> (r_o == R_W'(MUX_R)));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({m_o, n_o, r_o, freq_o}));

  p_err_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable({m_o, n_o, r_o, freq_o}));
endmodule

bind pll_coef_search pll_coef_search_chk #(
  .FREQ_W (FREQ_W),
  .FREF   (FREF),
  .M_W    (M_W),
  .N_W    (N_W),
  .R_W    (R_W),
  .REF_LO (REF_LO),
  .REF_HI (REF_HI),
  .MUX_R  (MUX_R),
  .TOL_DEN(TOL_DEN)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .m_o   (m_o),
  .n_o   (n_o),
  .r_o   (r_o),
  .freq_o(freq_o),
  .done_o(done_o),
  .err_o (err_o),
  .tgt_q (tgt_q),
  .mux_q (mux_q)
);

// File: tb/pll_coef_search_test.sv
module pll_coef_search_test;
  localparam longint FREF_HZ = 14_318_180;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mux = 1'b0;
  logic [31:0] tgt = '0;
  logic [6:0]  m_o;
  logic [4:0]  n_o;
  logic [1:0]  r_o;
  logic [31:0] freq_o;
  logic        done_o, err_o;

  int     n_chk = 0;
  int     n_bad = 0;
  bit     finished = 0;
  longint last_m = 0, last_n = 0, last_r = 0, last_f = 0;

  always #4 clk = ~clk;

  pll_coef_search uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .tgt_hz_i(tgt),
    .mux2x8_i(mux),
    .m_o     (m_o),
    .n_o     (n_o),
    .r_o     (r_o),
    .freq_o  (freq_o),
    .done_o  (done_o),
    .err_o   (err_o)
  );

  task automatic check_eq(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Arithmetic model written from the requirements.
  task automatic model(input longint t, input bit mx, output bit ok,
                       output longint m, output longint n, output longint r,
                       output longint f);
    longint d, q;
    ok = 0; m = 0; n = 0; f = 0; r = -1;
    if (mx) r = 2;
    else
      for (int rr = 0; rr <= 3; rr++)
        if ((t << rr) > 60_000_000 && (t << rr) <= 270_000_000) r = rr;
    if (r < 0) return;
    for (int nn = 31; nn >= 1; nn--) begin
      if (!(FREF_HZ > 600_000 * (nn + 2) && FREF_HZ <= 8_000_000 * (nn + 2))) continue;
      d = longint'(nn + 2) << r;
      q = (t * d + FREF_HZ / 2) / FREF_HZ;
      if (q < 3 || q > 129) continue;
      if (200 * q * FREF_HZ >= 199 * t * d && 200 * q * FREF_HZ < 201 * t * d) begin
        m = q - 2; n = nn; ok = 1;
      end
    end
    if (ok) f = (m + 2) * FREF_HZ / ((n + 2) << r);
  endtask

  task automatic run_case(input longint t, input bit mx, input bit interrupt);
    bit ok, held, got_done, got_err;
    longint em, en, er, ef;
    int cyc;
    model(t, mx, ok, em, en, er, ef);
    @(negedge clk);
    tgt = t[31:0]; mux = mx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tgt = 32'd99_999_999; mux = ~mx;  // latched value must be used
    held = 1; cyc = 0;
    while (cyc < 6000) begin
      if (done_o || err_o) break;
      if (m_o != last_m[6:0] || n_o != last_n[4:0] || r_o != last_r[1:0] ||
          freq_o != last_f[31:0]) held = 0;
      if (interrupt && cyc == 8) begin
        start = 1'b1; tgt = 32'd50_000_000; mux = 1'b0;
      end
      if (interrupt && cyc == 9) start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    got_done = done_o; got_err = err_o;
    check_eq("R11", "outputs held while busy", longint'(held), 1);
    check_eq("R9", "done/err exclusive", longint'(got_done && got_err), 0);
    if (ok) begin
      check_eq("R9", "done pulse", longint'(got_done), 1);
      check_eq(mx ? "R3" : "R2", "r", longint'(r_o), er);
      check_eq("R6", "n lowest accepted", longint'(n_o), en);
      check_eq("R4", "n inside ref window",
               longint'(FREF_HZ > 600_000 * (longint'(n_o) + 2) &&
                        FREF_HZ <= 8_000_000 * (longint'(n_o) + 2)), 1);
      check_eq("R5", "m", longint'(m_o), em);
      check_eq("R7", "freq", longint'(freq_o), ef);
      if (interrupt) check_eq("R10", "result of first target", longint'(freq_o), ef);
      last_m = em; last_n = en; last_r = er; last_f = ef;
    end else begin
      check_eq("R8", "err pulse", longint'(got_err), 1);
      check_eq("R8", "no done", longint'(got_done), 0);
      check_eq("R8", "m kept", longint'(m_o), last_m);
      check_eq("R8", "n kept", longint'(n_o), last_n);
      check_eq("R8", "r kept", longint'(r_o), last_r);
      check_eq("R8", "freq kept", longint'(freq_o), last_f);
    end
    @(negedge clk);
    check_eq("R9", "single-cycle completion", longint'(done_o || err_o), 0);
    if (interrupt) begin
      // the dropped start must not launch a second search
      repeat (1500) @(negedge clk);
      check_eq("R10", "no late completion", longint'(done_o || err_o), 0);
      check_eq("R10", "outputs untouched", longint'(freq_o), last_f);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_eq("R1", "m reset", longint'(m_o), 0);
    check_eq("R1", "n reset", longint'(n_o), 0);
    check_eq("R1", "r reset", longint'(r_o), 0);
    check_eq("R1", "freq reset", longint'(freq_o), 0);
    check_eq("R1", "flags reset", longint'(done_o || err_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2 band edges
    run_case(7_500_000, 0, 0);
    run_case(7_500_001, 0, 0);
    run_case(33_750_000, 0, 0);
    run_case(33_750_001, 0, 0);
    run_case(270_000_000, 0, 0);
    run_case(270_000_001, 0, 0);
    run_case(25_175_000, 0, 0);
    run_case(0, 0, 0);
    // R3 forced exponent, including out-of-reach targets
    run_case(100_000, 1, 0);
    run_case(200_000_000, 1, 0);
    run_case(40_000_000, 0, 1);
    for (int i = 0; i < 50; i++) run_case(64'd4_500_000 + 64'(i) * 64'd6_000_000, 0, 0);
    for (int i = 0; i < 18; i++) run_case(64'd1_000_000 + 64'(i) * 64'd7_000_000, 1, 0);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end
endmodule